// File: doc/BRIEF.md
# Scan Path Signature Register

This block is a 16-bit signature register that runs on the test clock of a scan bridge. In compaction mode it stays out of the scan chain. It watches the serial bits passing from the local scan ports toward the test data output and folds each bit into a running signature. Compaction happens only while the host TAP is in Shift-DR.

In select mode the register joins the active chain as a plain shift register. Its feedback is switched off, so a seed can be shifted in or a finished signature shifted out. The instruction decoder drives three control inputs and the host TAP supplies the Shift-DR indicator:

- a one-cycle strobe that turns compaction on;
- a one-cycle strobe that turns compaction off;
- a level that places the register in the chain.

Top module: `scan_sig_lfsr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register is cleared to 0 and compaction is switched off.
- R2: With compaction on, `sel_i` low and `shift_dr_i` high, the register takes `{fb, sig[15:1]}` on the edge. Here `fb = sig[0] ^ sig[4] ^ sig[11] ^ scan_bit_i`, which is the polynomial x^16 + x^12 + x^5 + 1 in Fibonacci form.
- R3: When `shift_dr_i` is low, the register keeps its value whatever the mode.
- R4: A `compact_on_i` strobe switches compaction on from the next edge. A shift in the same cycle as the strobe does not change the register.
- R5: A `compact_off_i` strobe stops compaction from the next edge, and the register keeps its current value.
- R6: With `sel_i` high and `shift_dr_i` high, the register takes `{scan_bit_i, sig[15:1]}` with no feedback. This holds whether or not compaction is on.
- R7: `sig_tdo_o` always equals bit 0 of the register. A seed shifted in during select mode comes back out LSB first after 16 shifts.
- R8: With compaction off and `sel_i` low, Shift-DR cycles leave the register unchanged.
- R9: When both strobes arrive in the same cycle, compaction ends up off.
- R10: Compaction stays on while `sel_i` is high. It resumes when `sel_i` falls, without a new `compact_on_i` strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low TAP reset |
| compact_on_i | input | 1 | One-cycle strobe that starts compaction |
| compact_off_i | input | 1 | One-cycle strobe that stops compaction |
| sel_i | input | 1 | Register is in the active chain (plain shift) |
| shift_dr_i | input | 1 | Host TAP is in Shift-DR |
| scan_bit_i | input | 1 | Serial scan bit, either observed or shifted in |
| sig_tdo_o | output | 1 | Serial output bit (register LSB) |
| sig_o | output | 16 | Current signature value |

## Verification
The bench builds the block with its default width of 16 and the default tap mask. It holds its own model of the R2 feedback bits, so a wrong tap position shows up within a few compaction cycles. Because the width is 16, a seed can be loaded and unloaded bit by bit in 32 cycles. That is short enough to check every bit of both the select path and the serial output.

// File: rtl/sig_lfsr_pkg.sv
// Package: shared types of the scan signature register.
package sig_lfsr_pkg;
    // Operating mode chosen for a cycle.
    typedef enum logic [1:0] {
        MODE_IDLE    = 2'd0,
        MODE_COMPACT = 2'd1,
        MODE_SELECT  = 2'd2
    } sig_mode_t;
endpackage

// File: rtl/sig_mode_ctrl.sv
// Mode controller: holds the compaction enable set and cleared by strobes,
// and decides the mode of the current cycle. Select wins over compaction.
// Assumes strobes are one cycle wide and synchronous to clk.
module sig_mode_ctrl
    import sig_lfsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      compact_on_i,
    input  logic      compact_off_i,
    input  logic      sel_i,
    output logic      compact_q,
    output sig_mode_t mode
);
    // Compaction enable flag; the off strobe has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            compact_q <= 1'b0;
        else if (compact_off_i)
            compact_q <= 1'b0;
        else if (compact_on_i)
            compact_q <= 1'b1;
    end

    // Mode of the current cycle.
    always_comb begin
        if (sel_i)
            mode = MODE_SELECT;
        else if (compact_q)
            mode = MODE_COMPACT;
        else
            mode = MODE_IDLE;
    end
endmodule

// File: rtl/sig_next.sv
// Next-state logic: a plain shift in select mode, or a feedback shift in
// compact mode. The serial bit enters at the MSB. Assumes TAP_MASK marks
// the state bits XORed into the feedback.
module sig_next
    import sig_lfsr_pkg::*;
#(
    parameter int          WIDTH    = 16,
    parameter logic [WIDTH-1:0] TAP_MASK = 16'h0811
) (
    input  logic [WIDTH-1:0] state,
    input  logic             din,
    input  sig_mode_t        mode,
    input  logic             shift_dr,
    output logic [WIDTH-1:0] nxt,
    output logic             load
);
    localparam int LSB_W = WIDTH - 1;

    logic [WIDTH-1:0] tapped;
    logic             fb;

    // Select the tapped bits for the feedback.
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_tap
            assign tapped[g] = state[g] & TAP_MASK[g];
        end
    endgenerate

    // Feedback bit of the compaction polynomial, folded with the input.
    always_comb fb = (^tapped) ^ din;

    // Choose the new value and whether to load it.
    always_comb begin
        load = shift_dr && (mode != MODE_IDLE);
        case (mode)
            MODE_SELECT:  nxt = {din, state[WIDTH-1 -: LSB_W]};
            MODE_COMPACT: nxt = {fb,  state[WIDTH-1 -: LSB_W]};
            default:      nxt = state;
        endcase
    end
endmodule

// File: rtl/sig_reg.sv
// State register of the signature, with a synchronous clear on reset.
module sig_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);
    // Clear on reset, load when enabled, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= nxt;
    end
endmodule

// File: rtl/scan_sig_lfsr.sv
// Top: scan path signature register. In compact mode it observes the
// scan stream during Shift-DR. In select mode it is a plain shift register
// in the chain. Assumes the instruction decoder drives strobes and the select level.
module scan_sig_lfsr
    import sig_lfsr_pkg::*;
#(
    parameter int               WIDTH    = 16,
    parameter logic [WIDTH-1:0] TAP_MASK = 16'h0811
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             compact_on_i,
    input  logic             compact_off_i,
    input  logic             sel_i,
    input  logic             shift_dr_i,
    input  logic             scan_bit_i,
    output logic             sig_tdo_o,
    output logic [WIDTH-1:0] sig_o
);
    sig_mode_t        mode;
    logic             compact_q;
    logic             load;
    logic [WIDTH-1:0] nxt;

    sig_mode_ctrl u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .compact_on_i  (compact_on_i),
        .compact_off_i (compact_off_i),
        .sel_i         (sel_i),
        .compact_q     (compact_q),
        .mode          (mode)
    );

    sig_next #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_next (
        .state    (sig_o),
        .din      (scan_bit_i),
        .mode     (mode),
        .shift_dr (shift_dr_i),
        .nxt      (nxt),
        .load     (load)
    );

    sig_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .nxt   (nxt),
        .q     (sig_o)
    );

    // Serial output is the register LSB.
    always_comb sig_tdo_o = sig_o[0];
endmodule

// File: rtl/scan_sig_lfsr_chk.sv
// Checker for scan_sig_lfsr, attached with bind below.
module scan_sig_lfsr_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             compact_on_i,
    input logic             compact_off_i,
    input logic             sel_i,
    input logic             shift_dr_i,
    input logic             scan_bit_i,
    input logic             compact_q,
    input logic [WIDTH-1:0] sig_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sig_o == '0 && !compact_q));

    // R3
    no_shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_dr_i |=> $stable(sig_o));

    // R6
    select_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && shift_dr_i) |=>
            sig_o == {$past(scan_bit_i), $past(sig_o[WIDTH-1:1])});

    // R2
    compact_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (compact_q && !sel_i && shift_dr_i) |=>
            sig_o[WIDTH-2:0] == $past(sig_o[WIDTH-1:1]));

    // R4
    compact_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (compact_on_i && !compact_off_i) |=> compact_q);

    // R5
    compact_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        compact_off_i |=> !compact_q);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!compact_q && !sel_i) |=> $stable(sig_o));
endmodule

bind scan_sig_lfsr scan_sig_lfsr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .compact_on_i  (compact_on_i),
    .compact_off_i (compact_off_i),
    .sel_i         (sel_i),
    .shift_dr_i    (shift_dr_i),
    .scan_bit_i    (scan_bit_i),
    .compact_q     (compact_q),
    .sig_o         (sig_o)
);

// File: tb/scan_sig_lfsr_test.sv
module scan_sig_lfsr_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int NVEC = 24;
    // vector bits: {sel, compact_on, compact_off, shift_dr, din}
    localparam logic [4:0] VECS [NVEC] = '{
        5'b01000, 5'b00011, 5'b00010, 5'b00011, 5'b00011, 5'b00001,
        5'b00010, 5'b00011, 5'b10011, 5'b10010, 5'b10011, 5'b00011,
        5'b00010, 5'b00111, 5'b00011, 5'b00010, 5'b01011, 5'b00011,
        5'b00011, 5'b01111, 5'b00011, 5'b11011, 5'b00010, 5'b00011
    };

    logic clk = 1'b0;
    logic rst_n, con, coff, sel, sh, din;
    logic sig_tdo;
    logic [W-1:0] sig;
    int checks = 0;
    int fails = 0;
    logic [W-1:0] m_reg;
    logic m_comp;

    scan_sig_lfsr uut (
        .clk(clk), .rst_n(rst_n), .compact_on_i(con), .compact_off_i(coff),
        .sel_i(sel), .shift_dr_i(sh), .scan_bit_i(din),
        .sig_tdo_o(sig_tdo), .sig_o(sig)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model of one edge, taken from the requirements.
    task automatic model_step();
        logic fb;
        if (!rst_n) begin
            m_reg = '0; m_comp = 1'b0;
        end else begin
            fb = m_reg[0] ^ m_reg[4] ^ m_reg[11] ^ din;
            if (sh && sel) m_reg = {din, m_reg[W-1:1]};
            else if (sh && m_comp) m_reg = {fb, m_reg[W-1:1]};
            if (coff) m_comp = 1'b0;
            else if (con) m_comp = 1'b1;
        end
    endtask

    // Apply inputs, clock once, sample after the edge.
    task automatic step(logic s, logic on, logic off, logic shv, logic d);
        sel = s; con = on; coff = off; sh = shv; din = d;
        model_step();
        @(posedge clk);
        #1;
        sel = 0; con = 0; coff = 0; sh = 0; din = 0;
    endtask

    initial begin
        logic [W-1:0] held;
        logic [W-1:0] seed;
        rst_n = 0; con = 0; coff = 0; sel = 0; sh = 0; din = 0;
        m_reg = '0; m_comp = 0;
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        check("R1 reset clears", sig, '0);
        rst_n = 1;

        // R4: strobe with a shift in the same cycle leaves register unchanged
        step(0, 1, 0, 1, 1);
        check("R4 same-cycle strobe", sig, '0);

        // Vector walk covering R2, R3, R5, R6, R9, R10
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i][4], VECS[i][3], VECS[i][2], VECS[i][1], VECS[i][0]);
            check("R2/R6 vector walk", sig, m_reg);
        end

        // R5: stop compaction, value kept
        step(0, 0, 1, 0, 0);
        held = sig;
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, i[0]);
        check("R5 off keeps value", sig, held);
        // R8: idle shifts ignored with a different pattern
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1'b1);
        check("R8 idle ignored", sig, held);

        // R6: load seed in select mode, no feedback
        seed = 16'hACE1;
        for (int i = 0; i < W; i++) step(1, 0, 0, 1, seed[i]);
        check("R6 seed loaded", sig, seed);
        // R7: shift out, LSB first
        for (int i = 0; i < W; i++) begin
            check("R7 serial out", {{(W-1){1'b0}}, sig_tdo}, {{(W-1){1'b0}}, seed[i]});
            step(1, 0, 0, 1, 1'b0);
        end
        check("R6 emptied", sig, '0);

        // R2: known compaction from zero; first 1 gives 8000, then feedback
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 1);
        check("R2 first fold", sig, 16'h8000);
        for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 1'b0);
        check("R2 feedback taps", sig, m_reg);

        // R3: no shift holds while compacting
        held = sig;
        step(0, 0, 0, 0, 1);
        check("R3 hold", sig, held);

        // R10: select then back, compaction continues
        step(1, 0, 0, 1, 1);
        step(0, 0, 0, 1, 1);
        check("R10 resume", sig, m_reg);

        // R9: both strobes -> off
        step(0, 1, 1, 0, 0);
        held = sig;
        step(0, 0, 0, 1, 1);
        check("R9 both strobes off", sig, held);

        // R1: reset mid-operation clears and disables compaction
        step(0, 1, 0, 0, 0);
        rst_n = 0;
        step(0, 0, 0, 0, 0);
        rst_n = 1;
        check("R1 reset mid-run", sig, '0);
        step(0, 0, 0, 1, 1);
        check("R1 compaction off after reset", sig, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule